// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 1M words by 16 bits. The host hands over one word access at a time through a valid/ready handshake carrying a read/write flag, a 20-bit word address, 16 bits of write data and a 2-bit byte mask. The block turns each access into the chip select pair (one active low, one active high), the active-low output and write enables, and the two active-low byte-lane enables. Each phase is held for a whole number of system clocks set by parameters. Read data comes back on `rd_data` together with a one-cycle `rd_valid` pulse.

Writes are ended by the write enable rising. The output enable stays high for the whole write. The block's own data drivers, which control the tri-state pads outside this block through `mem_dq_oe`, turn on only after the write enable has been low for one clock. They turn off one clock after it rises. Every access is followed by a gap of at least one clock with all strobes inactive. The address register loads only while the block is idle, so the address can change only while the chip is deselected.

The FSM has seven states. IDLE is the only state with `req_ready` high. In IDLE, a valid request is accepted and the FSM moves to RD_ACCESS for a read or to WR_SETUP for a write. RD_ACCESS lasts `RD_ACCESS_CYC` clocks. On its last clock the data is captured and the FSM moves to GAP. WR_SETUP lasts `WR_SETUP_CYC` clocks and moves to WR_TURN. WR_TURN lasts one clock and moves to WR_DRIVE. WR_DRIVE lasts `WR_DATA_CYC` clocks and moves to WR_HOLD. WR_HOLD lasts one clock and moves to GAP. GAP lasts `GAP_CYC` clocks and returns to IDLE. All count parameters must be at least 1. The write pulse is `WR_DATA_CYC + 1` clocks long, and the integrator sizes it to cover the RAM's output turn-off time plus its data setup time.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, `rd_valid` is 0, `mem_dq_oe` is 0, and every strobe is inactive: `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=1, `mem_ub_n`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle onward. A read keeps it low for `RD_ACCESS_CYC + GAP_CYC` cycles. A write keeps it low for `WR_SETUP_CYC + WR_DATA_CYC + 2 + GAP_CYC` cycles.
- R3: During the `RD_ACCESS_CYC` cycles after a read is accepted, the outputs are `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0, `mem_we_n`=1, `mem_lb_n`=!mask[0] and `mem_ub_n`=!mask[1]. Mask bit 0 selects data bits 7:0 and mask bit 1 selects data bits 15:8.
- R4: `rd_data` is sampled from `mem_dq_in` at the edge that ends the last read-access cycle. `rd_valid` is 1 for exactly the following cycle. The enabled lanes of `rd_data` then equal the RAM contents, and the disabled lanes are don't-care.
- R5: A write keeps `mem_oe_n`=1 throughout. It first holds the chip and the selected lanes enabled with `mem_we_n`=1 for `WR_SETUP_CYC` cycles. Then `mem_we_n` is 0 for exactly `WR_DATA_CYC + 1` cycles. Then one more cycle follows with the chip and lanes still selected and `mem_we_n`=1.
- R6: `mem_dq_oe` is 0 in the first cycle with `mem_we_n` low. It is 1 with `mem_dq_out` equal to the write data for the remaining low cycles and for exactly one cycle after `mem_we_n` rises, and 0 afterwards. It is never 1 while `mem_oe_n` is 0.
- R7: A write changes only the byte lanes whose mask bit is 1. The other lane of the addressed word keeps its old value.
- R8: `mem_addr` equals the accepted address from the cycle after acceptance until the block is idle again. It never changes while `mem_we_n` is 0.
- R9: After each access, for `GAP_CYC` cycles before `req_ready` returns, all strobes are inactive and `mem_dq_oe` is 0.
- R10: A request with mask 00 runs the full strobe sequence with both lane enables held at 1. A write with mask 00 leaves the RAM unchanged. A read with mask 00 still produces one `rd_valid` pulse.
- R11: A write produces no `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle pulse, read data on rd_data |
| rd_data | output | 16 | Captured read data |
| mem_addr | output | 20 | RAM address lines |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lb_n | output | 1 | Active-low lower-lane enable |
| mem_ub_n | output | 1 | Active-low upper-lane enable |
| mem_dq_out | output | 16 | Data toward the pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 16 | Data from the pads |

## Verification
The assertions assume that reset is applied before the first access and that the host treats `req_ready` as the only condition for acceptance. They do not assume that the request fields stay stable after acceptance, because the block latches them. The read-data rules assume that the RAM presents valid data once the access count has elapsed. The bench's RAM model enforces this: it returns a garbage pattern until the read strobes and the address have been stable for `RD_ACCESS_CYC - 1` sampled cycles, and on any lane that is disabled. The stimulus raises `req_valid` only when `req_ready` is seen and issues the next request in the same cycle that `req_ready` returns. This keeps every access back-to-back, so the gap and address rules are exercised at their tightest spacing.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_ACCESS = 3'd1,
        ST_WR_SETUP  = 3'd2,
        ST_WR_TURN   = 3'd3,
        ST_WR_DRIVE  = 3'd4,
        ST_WR_HOLD   = 3'd5,
        ST_GAP       = 3'd6
    } asram_state_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_req_reg.sv
`timescale 1ns/1ps
module asram_req_reg #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [LANES-1:0]  in_mask,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [LANES-1:0]  q_mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_wdata <= '0;
            q_mask  <= '0;
        end else if (load) begin
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            q_mask  <= in_mask;
        end
    end

endmodule

// File: rtl/asram_rd_capture.sv
`timescale 1ns/1ps
module asram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (capture && lane_en[g]) begin
                lane_q <= dq_in[g*LANE_W +: LANE_W];
            end
        end
        assign rd_data[g*LANE_W +: LANE_W] = lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int RD_ACCESS_CYC = 9,
    parameter int WR_SETUP_CYC  = 1,
    parameter int WR_DATA_CYC   = 6,
    parameter int GAP_CYC       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int LANES   = 2;
    localparam int MAX_CYC = int'(max_of4(RD_ACCESS_CYC, WR_SETUP_CYC, WR_DATA_CYC, GAP_CYC));
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] WS_LOAD  = CNT_W'(WR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] WD_LOAD  = CNT_W'(WR_DATA_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

    asram_state_e     state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             req_load;
    logic             cap_now;
    logic [LANES-1:0] q_mask;
    logic             chip_sel;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_load),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_mask  (req_mask),
        .q_addr   (mem_addr),
        .q_wdata  (mem_dq_out),
        .q_mask   (q_mask)
    );

    asram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cap_now),
        .lane_en  (q_mask),
        .dq_in    (mem_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, timer loads, request latch and capture strobe
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        req_load = 1'b0;
        cap_now  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    req_load = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = WS_LOAD;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    cap_now  = 1'b1;
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LOAD;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_d = ST_WR_TURN;
                end
            end
            ST_WR_TURN: begin
                state_d  = ST_WR_DRIVE;
                tmr_load = 1'b1;
                tmr_val  = WD_LOAD;
            end
            ST_WR_DRIVE: begin
                if (tmr_expired) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d  = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = GAP_LOAD;
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Strobe and driver outputs decoded from the state
    always_comb begin
        chip_sel   = 1'b0;
        req_ready  = 1'b0;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_RD_ACCESS: begin
                chip_sel = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_WR_SETUP:  chip_sel = 1'b1;
            ST_WR_TURN: begin
                chip_sel = 1'b1;
                mem_we_n = 1'b0;
            end
            ST_WR_DRIVE: begin
                chip_sel  = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                chip_sel  = 1'b1;
                mem_dq_oe = 1'b1;
            end
            ST_GAP:       chip_sel = 1'b0;
            default:      chip_sel = 1'b0;
        endcase
        mem_ce_n = !chip_sel;
        mem_ce2  = chip_sel;
        mem_lb_n = !(chip_sel && q_mask[0]);
        mem_ub_n = !(chip_sel && q_mask[1]);
    end

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int ADDR_W        = 20,
    parameter int RD_ACCESS_CYC = 9,
    parameter int WR_DATA_CYC   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);

    localparam int LIM   = (RD_ACCESS_CYC > WR_DATA_CYC + 1) ? RD_ACCESS_CYC : WR_DATA_CYC + 1;
    localparam int CW    = $clog2(LIM + 2);
    localparam logic [CW-1:0] WE_LEN = CW'(WR_DATA_CYC + 1);
    localparam logic [CW-1:0] OE_LEN = CW'(RD_ACCESS_CYC);

    logic [CW-1:0] we_lo_cnt;
    logic [CW-1:0] oe_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= mem_we_n ? '0 : we_lo_cnt + 1'b1;
            oe_lo_cnt <= mem_oe_n ? '0 : oe_lo_cnt + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe)); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_lo_cnt == OE_LEN)); // R3
    AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(mem_oe_n)); // R4
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R5
    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == WE_LEN)); // R5
    AST_DRV_LATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe); // R6
    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe); // R6
    AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> !mem_dq_oe); // R6
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_addr)); // R8

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .RD_ACCESS_CYC (RD_ACCESS_CYC),
    .WR_DATA_CYC   (WR_DATA_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

    localparam int RD = 9;
    localparam int WS = 1;
    localparam int WD = 6;
    localparam int GP = 1;
    localparam logic [15:0] JUNK = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = JUNK;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] ram     [int];
    logic [15:0] exp_mem [int];

    always #4 clk = ~clk;

    asram_ctrl #(
        .RD_ACCESS_CYC (RD),
        .WR_SETUP_CYC  (WS),
        .WR_DATA_CYC   (WD),
        .GAP_CYC       (GP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // RAM model sampled away from the active edge
    int          age = 0;
    bit          act_prev = 1'b0;
    logic        we_prev = 1'b1;
    logic [19:0] addr_prev = '0;
    always @(negedge clk) begin
        bit sel, act;
        logic [15:0] word;
        sel  = !mem_ce_n && mem_ce2;
        act  = sel && !mem_oe_n && mem_we_n;
        if (act && act_prev && mem_addr == addr_prev) age++;
        else age = 0;
        act_prev  = act;
        addr_prev = mem_addr;
        word = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
        if (sel && !we_prev && mem_we_n && mem_dq_oe) begin
            if (!mem_lb_n) word[7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) word[15:8] = mem_dq_out[15:8];
            ram[int'(mem_addr)] = word;
        end
        we_prev = mem_we_n;
        mem_dq_in[7:0]  <= (act && age >= RD - 1 && !mem_lb_n) ? word[7:0]  : JUNK[7:0];
        mem_dq_in[15:8] <= (act && age >= RD - 1 && !mem_ub_n) ? word[15:8] : JUNK[15:8];
    end

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [15:0] exp_word(input logic [19:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0000;
    endfunction

    // {ce_n, ce2, we_n, oe_n, lb_n, ub_n, dq_oe} expected k negedges after acceptance
    function automatic logic [6:0] exp_pins(input bit wr, input logic [1:0] m, input int k);
        logic [6:0] idle;
        idle = 7'b1011110;
        if (!wr) begin
            if (k < RD) return {1'b0, 1'b1, 1'b1, 1'b0, !m[0], !m[1], 1'b0};
            return idle;
        end
        if (k < WS)               return {1'b0, 1'b1, 1'b1, 1'b1, !m[0], !m[1], 1'b0};
        if (k == WS)              return {1'b0, 1'b1, 1'b0, 1'b1, !m[0], !m[1], 1'b0};
        if (k <= WS + WD)         return {1'b0, 1'b1, 1'b0, 1'b1, !m[0], !m[1], 1'b1};
        if (k == WS + WD + 1)     return {1'b0, 1'b1, 1'b1, 1'b1, !m[0], !m[1], 1'b1};
        return idle;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                           input logic [1:0] m, input string dtag);
        int total, busy, rv_cnt, rv_at;
        bit strobe_ok, drv_ok, gap_ok, addr_ok;
        logic [6:0] pins, ep, bad_pins, bad_exp;
        logic [15:0] got, lm, ew;
        total = wr ? (WS + WD + 2 + GP) : (RD + GP);
        busy = -1; rv_cnt = 0; rv_at = -1; got = '0;
        strobe_ok = 1'b1; drv_ok = 1'b1; gap_ok = 1'b1; addr_ok = 1'b1;
        bad_pins = '0; bad_exp = '0;
        while (!req_ready) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        for (int k = 0; k < total + 4; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (req_ready) begin
                busy = k;
                break;
            end
            pins = {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe};
            ep   = exp_pins(wr, m, k);
            if (pins[6:1] != ep[6:1]) begin
                if (ep == 7'b1011110) gap_ok = 1'b0; else strobe_ok = 1'b0;
                bad_pins = pins; bad_exp = ep;
            end
            if (pins[0] != ep[0] || (mem_dq_oe && mem_dq_out != d)) begin
                drv_ok = 1'b0; bad_pins = pins; bad_exp = ep;
            end
            if (mem_addr != a) addr_ok = 1'b0;
            if (rd_valid) begin
                rv_cnt++; rv_at = k; got = rd_data;
            end
        end
        check(busy == total, "R2", "busy cycles", busy, total);
        check(strobe_ok, wr ? "R5" : "R3", "strobe pattern", {25'd0, bad_pins}, {25'd0, bad_exp});
        check(drv_ok, "R6", "driver enable/data", {25'd0, bad_pins}, {25'd0, bad_exp});
        check(gap_ok, "R9", "gap strobes", {25'd0, bad_pins}, {25'd0, bad_exp});
        check(addr_ok, "R8", "address hold", {12'd0, mem_addr}, {12'd0, a});
        if (wr) begin
            check(rv_cnt == 0, "R11", "rd_valid during write", rv_cnt, 0);
            ew = exp_word(a);
            lm = lane_bits(m);
            exp_mem[int'(a)] = (ew & ~lm) | (d & lm);
        end else begin
            check(rv_cnt == 1 && rv_at == RD, dtag, "rd_valid timing", rv_at, RD);
            lm = lane_bits(m);
            ew = exp_word(a);
            check((got & lm) == (ew & lm), dtag, "read data", {16'd0, got & lm}, {16'd0, ew & lm});
        end
    endtask

    initial begin
        void'($urandom(32'h0051_7A3E));
        repeat (3) @(negedge clk);
        check(req_ready && !rd_valid && !mem_dq_oe, "R1", "ready/valid/oe in reset",
              {req_ready, rd_valid, mem_dq_oe}, 3'b100);
        check({mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 6'b101111, "R1",
              "strobes in reset", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 6'b101111);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rd_valid && !mem_dq_oe, "R1", "ready/valid/oe after reset",
              {req_ready, rd_valid, mem_dq_oe}, 3'b100);
        check({mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 6'b101111, "R1",
              "strobes after reset", {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 6'b101111);

        // Directed corner cases
        run_req(1'b1, 20'h00000, 16'h1234, 2'b11, "R4");
        run_req(1'b0, 20'h00000, 16'h0000, 2'b11, "R4");
        run_req(1'b1, 20'hFFFFF, 16'hABCD, 2'b11, "R4");
        run_req(1'b0, 20'hFFFFF, 16'h0000, 2'b11, "R4");
        run_req(1'b1, 20'h00000, 16'h5678, 2'b01, "R7");
        run_req(1'b0, 20'h00000, 16'h0000, 2'b11, "R7");
        run_req(1'b1, 20'h00000, 16'h9A00, 2'b10, "R7");
        run_req(1'b0, 20'h00000, 16'h0000, 2'b11, "R7");
        run_req(1'b1, 20'h00000, 16'hFFFF, 2'b00, "R10");
        run_req(1'b0, 20'h00000, 16'h0000, 2'b11, "R10");
        run_req(1'b0, 20'h00000, 16'h0000, 2'b00, "R10");
        run_req(1'b0, 20'hFFFFF, 16'h0000, 2'b10, "R4");

        // Constrained random, back to back
        for (int i = 0; i < 300; i++) begin
            bit wr;
            logic [19:0] a;
            logic [15:0] d;
            logic [1:0] m;
            wr = ($urandom % 2) == 1;
            a  = ($urandom % 4 == 0) ? 20'hFFFF8 + 20'($urandom % 8) : 20'($urandom % 8);
            d  = 16'($urandom);
            m  = 2'($urandom % 4);
            run_req(wr, a, d, m, m == 2'b00 ? "R10" : "R4");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule